// File: doc/BRIEF.md
# Double-Word Integer Add/Subtract Unit

This execution unit sits in the datapath of a 16-bit accumulator machine. It adds a signed integer to, or subtracts it from, the signed integer held in the A and B registers. Each of the two integers is one bit narrower than two words, and the result is written back into A and B. The other operand arrives already fetched as two words. Address generation, decode and the memory access all take place outside the unit. One start strobe runs one operation, and the unit registers the new A, B, LINK, overflow flag and condition codes on the next clock edge.

Overflow does not wrap. A result above the positive limit, or below the negative limit, is folded back into range with a forced sign bit. In either case the overflow flag is set. If the fault-enable key bit is also high, the unit raises a one-cycle fault pulse.

Bits are numbered here from the least significant end. With `WORD_W` bits per word, the value is `N = 2*WORD_W-1` bits wide. Its upper `WORD_W` bits are all of A, and its lower `WORD_W-1` bits are B bits `WORD_W-2:0`. The top bit of B carries no value.

Top module: `dword_addsub`

## Requirements
- R1: The A-side value is `{a_i, b_i[W-2:0]}` and the memory value is `{m_hi_i, m_lo_i[W-2:0]}`. Both are read as N-bit two's complement. Bit `W-1` of `b_i` and of `m_lo_i` has no effect on any output.
- R2: With `sub_i`=0 the true result r is the A-side value plus the memory value. With `sub_i`=1 it is the A-side value minus the memory value. When -2^(N-1) <= r < 2^(N-1), the result is r. `a_o` takes result bits N-1..W-1, `b_o[W-2:0]` takes result bits W-2..0, and `b_o[W-1]` is written 0.
- R3: When r >= 2^(N-1), the result MSB (`a_o[W-1]`) is 1. The lower N-1 result bits hold r - 2^(N-1), and `b_o[W-1]` is 0.
- R4: When r < -2^(N-1), the result MSB is 0. The lower N-1 result bits hold the low N-1 bits of -(r + 2^(N-1)), and `b_o[W-1]` is 0.
- R5: `cbit_o` is loaded with 1 on every operation that hits R3 or R4, and with 0 on every other operation.
- R6: `fault_o` is high for exactly the load cycle of an operation that hits R3 or R4 while `fault_en_i`=1. Otherwise it is low.
- R7: After an add, `link_o` is the carry out of the unsigned N-bit sum of the two bit patterns. After a subtract, it is 1 exactly when the A-side pattern is smaller, read unsigned, than the memory pattern.
- R8: `neg_o` equals the MSB of the written N-bit result. `zero_o` is 1 exactly when all N written result bits are 0.
- R9: Every output loads on the rising edge at which `start_i` is sampled high. `done_o` is high for exactly the cycles after such an edge. While `start_i` is low, `a_o`, `b_o`, `link_o`, `cbit_o`, `neg_o` and `zero_o` keep their values, and `fault_o` is low.
- R10: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run one operation at the next edge |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| fault_en_i | input | 1 | Key bit that makes overflow raise a fault |
| a_i | input | WORD_W | Current A register |
| b_i | input | WORD_W | Current B register (top bit unused) |
| m_hi_i | input | WORD_W | High memory word |
| m_lo_i | input | WORD_W | Low memory word (top bit unused) |
| a_o | output | WORD_W | New A register |
| b_o | output | WORD_W | New B register |
| link_o | output | 1 | Carry (add) or borrow (subtract) |
| cbit_o | output | 1 | Overflow flag |
| neg_o | output | 1 | Result negative |
| zero_o | output | 1 | Result zero |
| fault_o | output | 1 | Integer-exception fault pulse |
| done_o | output | 1 | Result loaded this cycle |

## Verification
The assertions assume that `start_i` is held low for as long as reset is asserted. They also assume that the inputs are stable around the sampling edge, so that `$past(start_i)` and the overflow class seen on the start cycle match what gets loaded. The bench drives every input on the falling edge and keeps `start_i` low through reset. It sweeps every pair of A-side and memory values of a 4-bit-word configuration, in both add and subtract, with the unused B top bits and the fault key toggled by pattern. This means that both fold directions, the unusable overflow extremes and the ignored bits all occur in the stimulus.

// File: rtl/dword_pkg.sv
package dword_pkg;
  typedef enum logic [1:0] {
    OVF_NONE = 2'd0,
    OVF_POS  = 2'd1,
    OVF_NEG  = 2'd2
  } ovf_e;
endpackage

// File: rtl/dword_join.sv
module dword_join #(
  parameter int WORD_W = 16,
  localparam int VAL_W = 2 * WORD_W - 1
) (
  input  logic [WORD_W-1:0] hi_i,
  input  logic [WORD_W-1:0] lo_i,
  output logic [VAL_W-1:0]  val_o
);
  // top bit of the low word holds no value (R1)
  logic unused_lo_top;
  assign unused_lo_top = lo_i[WORD_W-1];
  assign val_o = {hi_i, lo_i[WORD_W-2:0]};
endmodule

// File: rtl/dword_arith.sv
module dword_arith
  import dword_pkg::*;
#(
  parameter int VAL_W = 31
) (
  input  logic [VAL_W-1:0] a_i,
  input  logic [VAL_W-1:0] m_i,
  input  logic             sub_i,
  output logic [VAL_W:0]   sum_o,
  output ovf_e             ovf_o,
  output logic             link_o
);
  logic [VAL_W:0] a_ext, m_ext, uns_add, uns_sub;

  // one extra bit: true signed result never wraps
  assign a_ext = {a_i[VAL_W-1], a_i};
  assign m_ext = {m_i[VAL_W-1], m_i};
  assign sum_o = sub_i ? (a_ext - m_ext) : (a_ext + m_ext);

  assign uns_add = {1'b0, a_i} + {1'b0, m_i};
  assign uns_sub = {1'b0, a_i} - {1'b0, m_i};
  assign link_o  = sub_i ? uns_sub[VAL_W] : uns_add[VAL_W];

  always_comb begin
    unique case ({sum_o[VAL_W], sum_o[VAL_W-1]})
      2'b01:   ovf_o = OVF_POS;
      2'b10:   ovf_o = OVF_NEG;
      default: ovf_o = OVF_NONE;
    endcase
  end
endmodule

// File: rtl/dword_fold.sv
module dword_fold
  import dword_pkg::*;
#(
  parameter int VAL_W = 31
) (
  input  logic [VAL_W:0]   sum_i,
  input  ovf_e             ovf_i,
  output logic [VAL_W-1:0] res_o,
  output logic             neg_o,
  output logic             zero_o
);
  logic [VAL_W:0] sum_neg;

  // low N-1 bits of -(r + 2^(N-1)) equal those of -r
  assign sum_neg = -sum_i;

  always_comb begin
    unique case (ovf_i)
      OVF_POS: res_o = {1'b1, sum_i[VAL_W-2:0]};
      OVF_NEG: res_o = {1'b0, sum_neg[VAL_W-2:0]};
      default: res_o = sum_i[VAL_W-1:0];
    endcase
  end

  assign neg_o  = res_o[VAL_W-1];
  assign zero_o = (res_o == '0);
endmodule

// File: rtl/dword_addsub.sv
module dword_addsub
  import dword_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sub_i,
  input  logic              fault_en_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [WORD_W-1:0] m_hi_i,
  input  logic [WORD_W-1:0] m_lo_i,
  output logic [WORD_W-1:0] a_o,
  output logic [WORD_W-1:0] b_o,
  output logic              link_o,
  output logic              cbit_o,
  output logic              neg_o,
  output logic              zero_o,
  output logic              fault_o,
  output logic              done_o
);
  localparam int VAL_W = 2 * WORD_W - 1;
  localparam int LO_W  = WORD_W - 1;

  logic [VAL_W-1:0] acc_val, mem_val, res;
  logic [VAL_W:0]   sum;
  ovf_e             ovf;
  logic             link_n, neg_n, zero_n, exc;

  dword_join #(.WORD_W(WORD_W)) u_join_acc (
    .hi_i (a_i),
    .lo_i (b_i),
    .val_o(acc_val)
  );

  dword_join #(.WORD_W(WORD_W)) u_join_mem (
    .hi_i (m_hi_i),
    .lo_i (m_lo_i),
    .val_o(mem_val)
  );

  dword_arith #(.VAL_W(VAL_W)) u_arith (
    .a_i   (acc_val),
    .m_i   (mem_val),
    .sub_i (sub_i),
    .sum_o (sum),
    .ovf_o (ovf),
    .link_o(link_n)
  );

  dword_fold #(.VAL_W(VAL_W)) u_fold (
    .sum_i (sum),
    .ovf_i (ovf),
    .res_o (res),
    .neg_o (neg_n),
    .zero_o(zero_n)
  );

  assign exc = (ovf != OVF_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o     <= '0;
      b_o     <= '0;
      link_o  <= 1'b0;
      cbit_o  <= 1'b0;
      neg_o   <= 1'b0;
      zero_o  <= 1'b0;
      fault_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o  <= start_i;
      fault_o <= start_i & exc & fault_en_i;
      if (start_i) begin
        a_o    <= res[VAL_W-1:LO_W];
        b_o    <= {1'b0, res[LO_W-1:0]};
        link_o <= link_n;
        cbit_o <= exc;
        neg_o  <= neg_n;
        zero_o <= zero_n;
      end
    end
  end

  p_done_follows_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  p_done_needs_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i));
  p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(a_o) && $stable(b_o) && $stable(cbit_o) && !fault_o));
  p_fault_with_cbit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (cbit_o && done_o));
  p_b_top_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !b_o[WORD_W-1]);
  p_flags_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(neg_o && zero_o));
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ovf == OVF_NONE) |=> !cbit_o);
endmodule

// File: tb/dword_addsub_bench.sv
module dword_addsub_bench;
  localparam int W    = 4;
  localparam int N    = 2 * W - 1;
  localparam int HALF = 1 << (N - 1);
  localparam int FULL = 1 << N;
  localparam int LOM  = (1 << (W - 1)) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, sub_i = 1'b0, fault_en_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0, m_hi_i = '0, m_lo_i = '0;
  logic [W-1:0] a_o, b_o;
  logic link_o, cbit_o, neg_o, zero_o, fault_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dword_addsub #(.WORD_W(W)) u_dword_addsub (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .sub_i(sub_i),
    .fault_en_i(fault_en_i), .a_i(a_i), .b_i(b_i), .m_hi_i(m_hi_i),
    .m_lo_i(m_lo_i), .a_o(a_o), .b_o(b_o), .link_o(link_o),
    .cbit_o(cbit_o), .neg_o(neg_o), .zero_o(zero_o), .fault_o(fault_o),
    .done_o(done_o)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_op(int va, int vm, bit sub, bit sb, bit sm, bit en);
    int sa, smv, r, res, link;
    bit exc;
    string rtag;
    @(negedge clk);
    a_i        = W'(va >> (W - 1));
    b_i        = W'((int'(sb) << (W - 1)) | (va & LOM));
    m_hi_i     = W'(vm >> (W - 1));
    m_lo_i     = W'((int'(sm) << (W - 1)) | (vm & LOM));
    sub_i      = sub;
    fault_en_i = en;
    start_i    = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    sa  = (va >= HALF) ? va - FULL : va;
    smv = (vm >= HALF) ? vm - FULL : vm;
    r   = sub ? sa - smv : sa + smv;
    if (r >= HALF) begin
      res = r; exc = 1'b1; rtag = "R3";
    end else if (r < -HALF) begin
      res = (-(r + HALF)) & (HALF - 1); exc = 1'b1; rtag = "R4";
    end else begin
      res = r & (FULL - 1); exc = 1'b0; rtag = "R2";
    end
    if (sb || sm) rtag = {rtag, "/R1"};
    link = sub ? int'(va < vm) : int'((va + vm) >= FULL);
    check(int'(a_o) == (res >> (W - 1)), {rtag, " a_o"}, a_o, res >> (W - 1));
    check(int'(b_o) == (res & LOM), {rtag, " b_o"}, b_o, res & LOM);
    check(cbit_o == exc, "R5 cbit", cbit_o, exc);
    check(fault_o == (exc && en), "R6 fault", fault_o, exc && en);
    check(int'(link_o) == link, "R7 link", link_o, link);
    check(int'(neg_o) == ((res >> (N - 1)) & 1), "R8 neg", neg_o, (res >> (N - 1)) & 1);
    check(zero_o == (res == 0), "R8 zero", zero_o, res == 0);
    check(done_o == 1'b1, "R9 done", done_o, 1);
  endtask

  initial begin
    logic [W-1:0] ha, hb;
    logic hc, hl;
    repeat (3) @(negedge clk);
    // R10 reset state
    check({a_o, b_o, link_o, cbit_o, neg_o, zero_o, fault_o, done_o} == '0,
          "R10 reset", int'({a_o, b_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0, "R9 idle done", done_o, 0);

    for (int sub = 0; sub < 2; sub++)
      for (int va = 0; va < FULL; va++)
        for (int vm = 0; vm < FULL; vm++)
          do_op(va, vm, bit'(sub), bit'((va ^ vm) & 1), bit'((vm >> 1) & 1),
                bit'(((va >> 2) ^ vm) & 1));

    // R6/R9: fault drops and outputs hold once start is low
    do_op(HALF - 1, 1, 1'b0, 1'b0, 1'b0, 1'b1);
    ha = a_o; hb = b_o; hc = cbit_o; hl = link_o;
    a_i = '1; b_i = '0; m_hi_i = '1; m_lo_i = '1; sub_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(fault_o == 1'b0, "R6 single pulse", fault_o, 0);
      check(done_o == 1'b0, "R9 no done", done_o, 0);
      check(a_o == ha && b_o == hb, "R9 hold data", int'({a_o, b_o}), int'({ha, hb}));
      check(cbit_o == hc && link_o == hl, "R9 hold flags", int'({cbit_o, link_o}), int'({hc, hl}));
    end
    // R5: a clean operation clears a set cbit
    do_op(1, 1, 1'b0, 1'b1, 1'b1, 1'b1);
    check(cbit_o == 1'b0, "R5 clear after exc", cbit_o, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule